// File: doc/BRIEF.md
# Byte-Lane Synchronous SRAM

This block is a single-port synchronous static memory holding words of four byte lanes. It captures the address, write data, the three chip selects, the write controls and the sleep request on each rising clock edge. The captured command is then carried out one cycle later. Writes are self-timed from the captured registers, so the word written at one edge can be read back by a read captured at the very next edge. The bidirectional data bus is split into a read-data output and a drive flag, which stand in for the three-state buffers.

A static mode input selects how read data is returned. In flow-through timing, read data comes straight from the array in the cycle after the read is captured. In pipelined timing, read data passes through an output register and appears one cycle later. Output turn-off follows a single-cycle-deselect rule. A deselect, write or sleep cycle switches the drivers off in the cycle right after it is captured. In pipelined timing this means a read is shown only when another read follows it; otherwise it becomes a dummy read. An asynchronous active-low output enable can mask the drivers at any moment. Burst address sequencing is done outside this block, and the block simply takes an address every cycle.

A cycle-state machine tracks the captured command. It has five states: `ST_DESEL` (deselected), `ST_SLEEP`, `ST_WRITE`, `ST_READ_FIRST` (a read that follows a non-read) and `ST_READ_NEXT` (a read that follows a read). Each edge moves the machine according to the command captured at that edge:
- a deselect goes to `ST_DESEL`;
- a sleep request goes to `ST_SLEEP`;
- a write goes to `ST_WRITE`;
- a read goes to `ST_READ_NEXT` when the current state is `ST_READ_FIRST` or `ST_READ_NEXT`, and to `ST_READ_FIRST` from any other state.

Reset puts the machine in `ST_DESEL`.

Top module: `bytelane_sram`

## Requirements
- R1: A cycle is selected only when `sel1_n` is 0, `sel2` is 1 and `sel3_n` is 0. Any other combination is a deselect, which neither reads nor writes.
- R2: In a selected cycle, `all_wr_n` = 0 writes all four lanes whatever the other write inputs are. Otherwise, `lane_wr_en_n` = 0 writes each lane i whose `lane_sel_n[i]` is 0, and lane i is bits [8i+7:8i]. A selected cycle that writes no lane is a read.
- R3: With `pipe_mode` = 0 (flow-through), a read captured at edge k drives its word during the cycle that follows edge k.
- R4: With `pipe_mode` = 1 (pipelined), the word of a read captured at edge k is driven during the cycle that follows edge k+1, and only if a read is also captured at edge k+1. Otherwise it is not shown at all.
- R5: In either mode, a deselect or a write captured at an edge leaves `drive_o` at 0 for the cycle that follows that edge.
- R6: `out_en_n` acts without the clock. When it is 1, `drive_o` is 0. When it is 0, `drive_o` is 1 only while a read word is due to be presented.
- R7: `rdata_o` is all zeros whenever `drive_o` is 0.
- R8: `nap` = 1 at an edge blocks both read and write at that edge, and `drive_o` is 0 in the following cycle. Stored words are kept.
- R9: A read returns the newest data written to its address, including a write captured at the edge just before the read.
- R10: While reset is applied and right after it, `drive_o` is 0 and `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | LANES*LANE_W | Write data |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| all_wr_n | input | 1 | Whole-word write, active low, overrides lane controls |
| lane_wr_en_n | input | 1 | Lane write enable, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| nap | input | 1 | Sleep request, active high |
| pipe_mode | input | 1 | 0 = flow-through reads, 1 = pipelined reads (static) |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | LANES*LANE_W | Read data presented on the bus |
| drive_o | output | 1 | High while the data bus is driven |

## Verification
The assertions assume that `pipe_mode` changes only while the block is deselected. They also assume that `out_en_n` changes only away from clock edges, and that every synchronous input is steady around each rising edge. The bench meets these assumptions by driving all inputs on the falling edge. It changes the mode only between deselect cycles, and it toggles the output enable in the middle of a cycle. No address is read before it has been written, so every expected word is defined.

// File: rtl/sram_pkg.sv
package sram_pkg;

    // Command decoded from the pins sampled at a rising edge
    typedef enum logic [1:0] {
        CMD_DESEL = 2'd0,
        CMD_SLEEP = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_READ  = 2'd3
    } cmd_e;

    // State of the cycle captured at the most recent edge
    typedef enum logic [2:0] {
        ST_DESEL      = 3'd0,
        ST_SLEEP      = 3'd1,
        ST_WRITE      = 3'd2,
        ST_READ_FIRST = 3'd3,
        ST_READ_NEXT  = 3'd4
    } state_e;

endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
    import sram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             sel1_n,
    input  logic             sel2,
    input  logic             sel3_n,
    input  logic             nap,
    input  logic             all_wr_n,
    input  logic             lane_wr_en_n,
    input  logic [LANES-1:0] lane_sel_n,
    output cmd_e             cmd_o,
    output logic [LANES-1:0] mask_o
);

    logic selected;
    logic [LANES-1:0] lane_mask;

    assign selected = ~sel1_n & sel2 & ~sel3_n;

    // The whole-word write wins over the lane controls
    always_comb begin
        if (!all_wr_n) begin
            lane_mask = '1;
        end else if (!lane_wr_en_n) begin
            lane_mask = ~lane_sel_n;
        end else begin
            lane_mask = '0;
        end
    end

    always_comb begin
        if (!selected) begin
            cmd_o = CMD_DESEL;
        end else if (nap) begin
            cmd_o = CMD_SLEEP;
        end else if (|lane_mask) begin
            cmd_o = CMD_WRITE;
        end else begin
            cmd_o = CMD_READ;
        end
    end

    assign mask_o = lane_mask;

endmodule

// File: rtl/sram_cycle_fsm.sv
module sram_cycle_fsm
    import sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [LANES-1:0]  mask_i,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [LANES-1:0]  mask_q,
    output logic              commit_wr,
    output logic              rd_now,
    output logic              rd_shown
);

    state_e state_q;
    state_e state_d;

    // Next state from the command sampled at this edge
    always_comb begin
        state_d = state_q;
        unique case (cmd_i)
            CMD_DESEL: state_d = ST_DESEL;
            CMD_SLEEP: state_d = ST_SLEEP;
            CMD_WRITE: state_d = ST_WRITE;
            CMD_READ: begin
                if (state_q == ST_READ_FIRST || state_q == ST_READ_NEXT) begin
                    state_d = ST_READ_NEXT;
                end else begin
                    state_d = ST_READ_FIRST;
                end
            end
            default: state_d = ST_DESEL;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DESEL;
        end else begin
            state_q <= state_d;
        end
    end

    // Input capture registers (no reset needed on the datapath)
    always_ff @(posedge clk) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        mask_q  <= mask_i;
    end

    // Outputs of the state machine
    always_comb begin
        commit_wr = 1'b0;
        rd_now    = 1'b0;
        rd_shown  = 1'b0;
        unique case (state_q)
            ST_DESEL:      ;
            ST_SLEEP:      ;
            ST_WRITE:      commit_wr = 1'b1;
            ST_READ_FIRST: rd_now = 1'b1;
            ST_READ_NEXT: begin
                rd_now   = 1'b1;
                rd_shown = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [LANES-1:0]  wr_mask,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[g]) begin
                cells[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[addr];
    end

endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_mode,
    input  logic              out_en_n,
    input  logic              rd_now,
    input  logic              rd_shown,
    input  logic [DATA_W-1:0] array_q,
    output logic [DATA_W-1:0] rdata_o,
    output logic              drive_o
);

    logic [DATA_W-1:0] hold_q;
    logic              want_drive;
    logic [DATA_W-1:0] word;

    // Output register of the pipelined path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (rd_now) begin
            hold_q <= array_q;
        end
    end

    assign want_drive = pipe_mode ? rd_shown : rd_now;
    assign word       = pipe_mode ? hold_q : array_q;
    assign drive_o    = want_drive & ~out_en_n;
    assign rdata_o    = drive_o ? word : '0;

endmodule

// File: rtl/bytelane_sram.sv
module bytelane_sram
    import sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              sel1_n,
    input  logic              sel2,
    input  logic              sel3_n,
    input  logic              all_wr_n,
    input  logic              lane_wr_en_n,
    input  logic [LANES-1:0]  lane_sel_n,
    input  logic              nap,
    input  logic              pipe_mode,
    input  logic              out_en_n,
    output logic [DATA_W-1:0] rdata_o,
    output logic              drive_o
);

    cmd_e              cmd;
    logic [LANES-1:0]  mask;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  mask_q;
    logic              commit_wr;
    logic              rd_now;
    logic              rd_shown;
    logic [DATA_W-1:0] array_q;

    sram_cmd_decode #(.LANES(LANES)) u_dec (
        .sel1_n       (sel1_n),
        .sel2         (sel2),
        .sel3_n       (sel3_n),
        .nap          (nap),
        .all_wr_n     (all_wr_n),
        .lane_wr_en_n (lane_wr_en_n),
        .lane_sel_n   (lane_sel_n),
        .cmd_o        (cmd),
        .mask_o       (mask)
    );

    sram_cycle_fsm #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_i     (cmd),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .mask_i    (mask),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .mask_q    (mask_q),
        .commit_wr (commit_wr),
        .rd_now    (rd_now),
        .rd_shown  (rd_shown)
    );

    sram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .wr_en   (commit_wr),
        .wr_mask (mask_q),
        .addr    (addr_q),
        .wdata   (wdata_q),
        .rdata   (array_q)
    );

    sram_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .pipe_mode (pipe_mode),
        .out_en_n  (out_en_n),
        .rd_now    (rd_now),
        .rd_shown  (rd_shown),
        .array_q   (array_q),
        .rdata_o   (rdata_o),
        .drive_o   (drive_o)
    );

endmodule

// File: rtl/sram_rules_chk.sv
module sram_rules_chk #(
    parameter int LANES  = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel1_n,
    input logic              sel2,
    input logic              sel3_n,
    input logic              all_wr_n,
    input logic              lane_wr_en_n,
    input logic [LANES-1:0]  lane_sel_n,
    input logic              nap,
    input logic              pipe_mode,
    input logic              out_en_n,
    input logic [DATA_W-1:0] rdata_o,
    input logic              drive_o
);

    logic picked;
    logic wants_wr;
    logic rd_seen;

    assign picked   = ~sel1_n & sel2 & ~sel3_n;
    assign wants_wr = ~all_wr_n | (~lane_wr_en_n & (|(~lane_sel_n)));
    assign rd_seen  = picked & ~nap & ~wants_wr;

    AST_OE_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !drive_o);  // R6

    AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_o |-> (rdata_o == '0));  // R7

    AST_DESEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !picked |=> !drive_o);  // R1

    AST_WRITE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (picked && !nap && wants_wr) |=> !drive_o);  // R5

    AST_NAP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        nap |=> !drive_o);  // R8

    AST_FLOW_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && drive_o) |-> $past(rd_seen));  // R3

    AST_PIPE_TWO_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && drive_o) |-> ($past(rd_seen) && $past(rd_seen, 2)));  // R4

endmodule

bind bytelane_sram sram_rules_chk #(.LANES(LANES), .DATA_W(DATA_W)) u_rules (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel1_n       (sel1_n),
    .sel2         (sel2),
    .sel3_n       (sel3_n),
    .all_wr_n     (all_wr_n),
    .lane_wr_en_n (lane_wr_en_n),
    .lane_sel_n   (lane_sel_n),
    .nap          (nap),
    .pipe_mode    (pipe_mode),
    .out_en_n     (out_en_n),
    .rdata_o      (rdata_o),
    .drive_o      (drive_o)
);

// File: tb/sim_bytelane_sram.sv
module sim_bytelane_sram;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic        sel1_n = 1'b0;
    logic        sel2 = 1'b0;
    logic        sel3_n = 1'b0;
    logic        all_wr_n = 1'b1;
    logic        lane_wr_en_n = 1'b1;
    logic [3:0]  lane_sel_n = 4'hF;
    logic        nap = 1'b0;
    logic        pipe_mode = 1'b0;
    logic        out_en_n = 1'b0;
    logic [31:0] rdata_o;
    logic        drive_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bytelane_sram u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_i       (addr_i),
        .wdata_i      (wdata_i),
        .sel1_n       (sel1_n),
        .sel2         (sel2),
        .sel3_n       (sel3_n),
        .all_wr_n     (all_wr_n),
        .lane_wr_en_n (lane_wr_en_n),
        .lane_sel_n   (lane_sel_n),
        .nap          (nap),
        .pipe_mode    (pipe_mode),
        .out_en_n     (out_en_n),
        .rdata_o      (rdata_o),
        .drive_o      (drive_o)
    );

    // Flow-through vectors: all_n, lane_en_n, lane_sel_n, addr, wdata, exp_drive, exp_data
    typedef struct packed {
        logic        all_n;
        logic        len_n;
        logic [3:0]  lsel_n;
        logic [5:0]  addr;
        logic [31:0] wd;
        logic        drv;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t TBL [11] = '{
        '{1'b0, 1'b1, 4'hF, 6'd1, 32'h11223344, 1'b0, 32'h0},
        '{1'b0, 1'b1, 4'hF, 6'd2, 32'hAABBCCDD, 1'b0, 32'h0},
        '{1'b1, 1'b0, 4'hA, 6'd2, 32'h55667788, 1'b0, 32'h0},
        '{1'b1, 1'b1, 4'hF, 6'd2, 32'h0,        1'b1, 32'hAA66CC88},
        '{1'b1, 1'b1, 4'hF, 6'd1, 32'h0,        1'b1, 32'h11223344},
        '{1'b0, 1'b1, 4'hF, 6'd1, 32'h99999999, 1'b0, 32'h0},
        '{1'b1, 1'b1, 4'h0, 6'd1, 32'h0,        1'b1, 32'h99999999},
        '{1'b1, 1'b0, 4'h7, 6'd2, 32'h12345678, 1'b0, 32'h0},
        '{1'b1, 1'b1, 4'hF, 6'd2, 32'h0,        1'b1, 32'h1266CC88},
        '{1'b0, 1'b0, 4'hE, 6'd3, 32'hDEADBEEF, 1'b0, 32'h0},
        '{1'b1, 1'b1, 4'hF, 6'd3, 32'h0,        1'b1, 32'hDEADBEEF}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic put(input logic en, input logic aw_n, input logic lw_n,
                       input logic [3:0] ls_n, input logic [5:0] a, input logic [31:0] d);
        sel1_n       = 1'b0;
        sel2         = en;
        sel3_n       = 1'b0;
        all_wr_n     = aw_n;
        lane_wr_en_n = lw_n;
        lane_sel_n   = ls_n;
        addr_i       = a;
        wdata_i      = d;
    endtask

    task automatic rd(input logic [5:0] a);
        put(1'b1, 1'b1, 1'b1, 4'hF, a, 32'h0);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        put(1'b1, 1'b0, 1'b1, 4'hF, a, d);
    endtask

    task automatic idle();
        put(1'b0, 1'b1, 1'b1, 4'hF, 6'd0, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        chk("R10 drive in reset", {31'b0, drive_o}, 32'h0);
        chk("R10 data in reset", rdata_o, 32'h0);
        rst_n = 1'b1;
        step();
        chk("R10 drive after reset", {31'b0, drive_o}, 32'h0);

        // Table walk in flow-through mode: R2 lane writes, R3 timing, R9 newest data
        for (int i = 0; i < 11; i++) begin
            put(1'b1, TBL[i].all_n, TBL[i].len_n, TBL[i].lsel_n, TBL[i].addr, TBL[i].wd);
            step();
            chk($sformatf("R2 R3 R9 row %0d drive", i), {31'b0, drive_o}, {31'b0, TBL[i].drv});
            chk($sformatf("R2 R3 R9 row %0d data", i), rdata_o, TBL[i].exp);
        end

        // R1: chip-select combinations
        put(1'b1, 1'b0, 1'b1, 4'hF, 6'd1, 32'h0);
        sel3_n = 1'b1;
        step();
        chk("R1 sel3_n high write", {31'b0, drive_o}, 32'h0);
        rd(6'd1); sel2 = 1'b0;
        step();
        chk("R1 sel2 low read", {31'b0, drive_o}, 32'h0);
        rd(6'd1); sel1_n = 1'b1;
        step();
        chk("R1 sel1_n high read", {31'b0, drive_o}, 32'h0);
        rd(6'd1);
        step();
        chk("R1 deselected write ignored", rdata_o, 32'h99999999);

        // R6: asynchronous output enable
        rd(6'd2); out_en_n = 1'b1;
        step();
        chk("R6 masked drive", {31'b0, drive_o}, 32'h0);
        chk("R7 masked data", rdata_o, 32'h0);
        #2 out_en_n = 1'b0;
        #1 chk("R6 async enable drive", {31'b0, drive_o}, 32'h1);
        chk("R6 async enable data", rdata_o, 32'h1266CC88);
        idle();
        step();
        out_en_n = 1'b0;
        #1 chk("R6 no read presented", {31'b0, drive_o}, 32'h0);

        // R5: write after read turns the bus off
        rd(6'd3);
        step();
        chk("R5 read before write", rdata_o, 32'hDEADBEEF);
        wr(6'd4, 32'h0BADF00D);
        step();
        chk("R5 write cycle off", {31'b0, drive_o}, 32'h0);

        // R8: sleep blocks accesses and keeps contents
        wr(6'd2, 32'hFFFFFFFF); nap = 1'b1;
        step();
        chk("R8 sleep write off", {31'b0, drive_o}, 32'h0);
        rd(6'd2);
        step();
        chk("R8 sleep read off", {31'b0, drive_o}, 32'h0);
        nap = 1'b0;
        rd(6'd2);
        step();
        chk("R8 contents kept", rdata_o, 32'h1266CC88);

        // R4: pipelined reads with single-cycle deselect
        idle();
        step();
        pipe_mode = 1'b1;
        step();
        rd(6'd1);
        step();
        chk("R4 first read hidden", {31'b0, drive_o}, 32'h0);
        rd(6'd2);
        step();
        chk("R4 word of read one", rdata_o, 32'h99999999);
        rd(6'd3);
        step();
        chk("R4 word of read two", rdata_o, 32'h1266CC88);
        idle();
        step();
        chk("R4 R5 deselect cuts dummy read", {31'b0, drive_o}, 32'h0);
        rd(6'd3);
        step();
        wr(6'd6, 32'h600DCAFE);
        step();
        chk("R4 R5 read then write off", {31'b0, drive_o}, 32'h0);
        rd(6'd6);
        step();
        chk("R4 read after write hidden", {31'b0, drive_o}, 32'h0);
        rd(6'd6);
        step();
        chk("R4 R9 pipelined newest data", rdata_o, 32'h600DCAFE);
        idle();
        step();
        pipe_mode = 1'b0;
        step();

        // R9: flow-through read right after a write
        wr(6'd7, 32'h77007700);
        step();
        rd(6'd7);
        step();
        chk("R9 flow newest data", rdata_o, 32'h77007700);
        rd(6'd4);
        step();
        chk("R5 R9 earlier write stored", rdata_o, 32'h0BADF00D);
        idle();
        step();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule